// File: doc/BRIEF.md
# Two-Stage Cascaded Digital Noise Shaper

This block turns a stream of signed multi-bit samples into a short signed word whose quantization error falls off at low frequencies with second-order slope. Two first-order loops do the work. Each loop has an accumulator with one sample of delay and a two-level decision, and the decision is subtracted back at the accumulator input. The first loop takes the input sample. The second loop takes the first loop's leftover error, held back by one sample. A small recombination network then merges the two decision streams so that the first loop's error cancels out. The result is the input delayed by three samples, plus the second loop's error shaped by (1-z^-1)^2.

The datapath moves forward by exactly one step on each cycle in which the sample enable is high. That makes it suitable for a wide system clock whose sample rate is set by a strobe. A decimation filter downstream consumes the output word together with its valid flag.

A three-state sequencer tracks how far the pipeline has filled. ST_IDLE is the state after reset. The first enabled sample moves it to ST_FILL. In ST_FILL it counts enabled samples, and the fourth one moves it to ST_RUN. ST_RUN holds until a synchronous reset returns the sequencer to ST_IDLE. The valid flag is high exactly in ST_RUN.

Top module: `ns2_cascade`

## Requirements
- R1: With FS = 2^(W-1)-1, each loop decides +FS when its accumulator is at or above zero and -FS when it is below zero. On every enabled step the accumulator adds its input and subtracts the current decision.
- R2: The second loop's input is the first loop's residual (accumulator minus decision), registered on the previous enabled step. Its magnitude never exceeds FS.
- R3: The output word is 3-bit two's complement in units of FS. It equals d2[n] - d2[n-1] + d1[n-2], where d1 and d2 are the decisions (+1 or -1) and the indices count enabled steps. It always lies in -3..+3.
- R4: The cascade realises Y = z^-3·X + (1-z^-1)^2·Q2. For a constant input, FS times the sum of 64 consecutive valid outputs is within 4·FS of 64 times the input.
- R5: For inputs within ±FS, both accumulators stay within ±2·FS. They are W+2 bits wide and never wrap.
- R6: The input code -2^(W-1) is treated exactly as -FS.
- R7: In a cycle with the sample enable low, no state changes. The output word and the valid flag keep their values.
- R8: A synchronous reset clears the accumulators, the residual register, the delay registers and the output. It forces valid low and the sequencer to ST_IDLE, and it takes priority over a simultaneous sample enable.
- R9: The valid flag rises on the clock edge of the fourth enabled sample after reset. It stays high until the next reset. That first valid word already contains the first input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Advance the datapath one sample step |
| smp_in | input | W | Signed input sample |
| dout | output | 3 | Signed shaped output in units of FS |
| dout_valid | output | 1 | Output word is meaningful (sequencer in ST_RUN) |

## Verification
A synchronous reset and a sample enable can arrive in the same cycle. The bench provokes this by raising both in the middle of a long random run that carries non-zero accumulator state. It then judges the outcome in two ways. The output must be zero and valid must be low right after that edge. The subsequent stream must match a reference model restarted from zero, and the valid flag must take exactly four fresh enables to return. Idle cycles inserted between samples confirm that a low enable freezes the output and the valid flag.

// File: rtl/ns2_pkg.sv
package ns2_pkg;

    localparam int OUT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } ns2_state_e;

    // Map a decision bit to its level in units of full scale.
    function automatic logic signed [OUT_W-1:0] unit_level(input logic up);
        return up ? 3'sd1 : -3'sd1;
    endfunction

endpackage

// File: rtl/ns2_stage.sv
module ns2_stage #(
    parameter int W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [W+1:0]  din,
    output logic signed [W+1:0]  acc,
    output logic                 decide
);
    localparam int AW = W + 2;
    localparam logic signed [AW-1:0] FS = AW'((1 << (W - 1)) - 1);

    logic signed [AW-1:0] level;

    always_comb begin
        decide = ~acc[AW-1];
        level  = decide ? FS : -FS;
    end

    // Delaying integrator: the difference formed now shows up one step later.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + din - level;
        end
    end

endmodule

// File: rtl/ns2_recomb.sv
module ns2_recomb
    import ns2_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    b1,
    input  logic                    b2,
    output logic signed [OUT_W-1:0] y
);
    logic b2_d;
    logic b1_d;
    logic b1_dd;
    logic signed [OUT_W-1:0] sum;

    // Differentiate stage two, delay stage one twice, then add.
    always_comb begin
        sum = unit_level(b2) - unit_level(b2_d) + unit_level(b1_dd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b2_d  <= 1'b0;
            b1_d  <= 1'b0;
            b1_dd <= 1'b0;
            y     <= '0;
        end else if (en) begin
            b2_d  <= b2;
            b1_d  <= b1;
            b1_dd <= b1_d;
            y     <= sum;
        end
    end

endmodule

// File: rtl/ns2_seq.sv
module ns2_seq
    import ns2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic valid
);
    ns2_state_e state;
    ns2_state_e state_nxt;
    logic [1:0] fill_cnt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (en) state_nxt = ST_FILL;
            ST_FILL: if (en && fill_cnt == 2'd3) state_nxt = ST_RUN;
            ST_RUN:  state_nxt = ST_RUN;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            fill_cnt <= 2'd0;
        end else if (en) begin
            state    <= state_nxt;
            fill_cnt <= (fill_cnt == 2'd3) ? fill_cnt : fill_cnt + 2'd1;
        end
    end

    always_comb begin
        valid = (state == ST_RUN);
    end

endmodule

// File: rtl/ns2_cascade.sv
module ns2_cascade
    import ns2_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_en,
    input  logic [W-1:0]            smp_in,
    output logic signed [OUT_W-1:0] dout,
    output logic                    dout_valid
);
    localparam int AW = W + 2;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [AW-1:0] FS = AW'((1 << (W - 1)) - 1);

    logic [W-1:0]         x_c;
    logic signed [AW-1:0] x_ext;
    logic signed [AW-1:0] acc1;
    logic signed [AW-1:0] acc2;
    logic signed [AW-1:0] res1;
    logic signed [AW-1:0] res1_q;
    logic                 dec1;
    logic                 dec2;

    // Fold the lone most-negative code onto -FS so the range is symmetric.
    always_comb begin
        x_c   = (smp_in == MOST_NEG) ? (MOST_NEG | W'(1)) : smp_in;
        x_ext = {{2{x_c[W-1]}}, x_c};
        res1  = acc1 - (dec1 ? FS : -FS);
    end

    ns2_stage #(.W(W)) stage1_i (
        .clk    (clk),
        .rst    (rst),
        .en     (smp_en),
        .din    (x_ext),
        .acc    (acc1),
        .decide (dec1)
    );

    // The residual is held one step so the second loop sees -Q1 delayed.
    always_ff @(posedge clk) begin
        if (rst) begin
            res1_q <= '0;
        end else if (smp_en) begin
            res1_q <= res1;
        end
    end

    ns2_stage #(.W(W)) stage2_i (
        .clk    (clk),
        .rst    (rst),
        .en     (smp_en),
        .din    (res1_q),
        .acc    (acc2),
        .decide (dec2)
    );

    ns2_recomb recomb_i (
        .clk (clk),
        .rst (rst),
        .en  (smp_en),
        .b1  (dec1),
        .b2  (dec2),
        .y   (dout)
    );

    ns2_seq seq_i (
        .clk   (clk),
        .rst   (rst),
        .en    (smp_en),
        .valid (dout_valid)
    );

endmodule

// File: rtl/ns2_cascade_chk.sv
module ns2_cascade_chk #(
    parameter int W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic signed [W+1:0] acc1,
    input logic signed [W+1:0] acc2,
    input logic signed [W+1:0] res1,
    input logic signed [2:0]   y,
    input logic                vld
);
    localparam int AW = W + 2;
    localparam logic signed [AW-1:0] FS1 = AW'((1 << (W - 1)) - 1);
    localparam logic signed [AW-1:0] FS2 = AW'(2 * ((1 << (W - 1)) - 1));

    assert_acc_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (acc1 >= -FS2) && (acc1 <= FS2) && (acc2 >= -FS2) && (acc2 <= FS2));

    assert_res_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (res1 >= -FS1) && (res1 <= FS1));

    assert_out_range_R3: assert property (@(posedge clk) disable iff (rst)
        vld |-> (y != 3'sb100));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(y) && $stable(vld)));

    assert_valid_keep_R9: assert property (@(posedge clk) disable iff (rst)
        vld |=> vld);

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!vld && y == 3'sd0));

endmodule

bind ns2_cascade ns2_cascade_chk #(.W(W)) chk_i (
    .clk  (clk),
    .rst  (rst),
    .en   (smp_en),
    .acc1 (acc1),
    .acc2 (acc2),
    .res1 (res1),
    .y    (dout),
    .vld  (dout_valid)
);

// File: tb/ns2_cascade_tb_top.sv
module ns2_cascade_tb_top;
    localparam int W  = 12;
    localparam int FS = (1 << (W - 1)) - 1;

    typedef struct {
        bit vld;
        int val;
        bit chk;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                smp_en = 1'b0;
    logic [W-1:0]        smp_in = '0;
    logic signed [2:0]   dout;
    logic                dout_valid;

    int   checks = 0;
    int   failures = 0;
    exp_t sb[$];
    bit   armed = 0;
    bit   win = 0;
    int   obs_sum = 0;

    // reference model state
    int m_v1, m_v2, m_r, m_fill, m_y1p, m_y1pp, m_y2p;

    always #2 clk = ~clk;

    ns2_cascade #(.W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .smp_en     (smp_en),
        .smp_in     (smp_in),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    task automatic model_clear();
        m_v1 = 0; m_v2 = 0; m_r = 0; m_fill = 0;
        m_y1p = -1; m_y1pp = -1; m_y2p = -1;
    endtask

    // R1 R2 R3 R6 R9: expected output from the stated equations
    task automatic model_step(input int x, output exp_t it);
        int xc, d1, d2, nv1, nv2, nr;
        xc = (x == -(1 << (W - 1))) ? -FS : x;
        d1 = (m_v1 >= 0) ? 1 : -1;
        d2 = (m_v2 >= 0) ? 1 : -1;
        m_fill++;
        it.vld = (m_fill >= 4);
        it.val = d2 - m_y2p + m_y1pp;
        it.chk = it.vld;
        nv1 = m_v1 + xc - d1 * FS;
        nr  = m_v1 - d1 * FS;
        nv2 = m_v2 + m_r - d2 * FS;
        m_v1 = nv1; m_r = nr; m_v2 = nv2;
        m_y1pp = m_y1p; m_y1p = d1; m_y2p = d2;
    endtask

    task automatic step(input int x);
        exp_t it;
        smp_in = W'(x);
        smp_en = 1'b1;
        model_step(x, it);
        sb.push_back(it);
        @(negedge clk);
        smp_en = 1'b0;
    endtask

    // R8: reset, optionally together with a sample enable
    task automatic rst_cycle(input bit with_en, input int x);
        exp_t it;
        rst = 1'b1;
        smp_en = with_en;
        smp_in = W'(x);
        armed = 1;
        model_clear();
        it.vld = 0; it.val = 0; it.chk = 1;
        sb.push_back(it);
        @(negedge clk);
        rst = 1'b0;
        smp_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        bit e, r, w, a;
        logic signed [2:0] last_y;
        logic last_v;
        exp_t it;
        last_y = '0;
        last_v = 1'b0;
        forever begin
            @(posedge clk);
            e = smp_en; r = rst; w = win; a = armed;
            @(negedge clk);
            if (a) begin
                if (r || e) begin
                    if (sb.size() == 0) begin
                        failures++;
                        $display("FAIL R3 scoreboard empty actual=%0d expected=item", dout);
                    end else begin
                        it = sb.pop_front();
                        checks++;
                        if (dout_valid !== it.vld) begin
                            failures++;
                            $display("FAIL R9 valid actual=%0b expected=%0b", dout_valid, it.vld);
                        end
                        if (it.chk) begin
                            checks++;
                            if (dout !== 3'(it.val)) begin
                                failures++;
                                $display("FAIL %s output actual=%0d expected=%0d",
                                         r ? "R8" : "R3", dout, it.val);
                            end
                        end
                        if (w && dout_valid) obs_sum += int'(dout);
                    end
                end else begin
                    checks++;
                    if (dout !== last_y || dout_valid !== last_v) begin
                        failures++;
                        $display("FAIL R7 hold actual=%0d/%0b expected=%0d/%0b",
                                 dout, dout_valid, last_y, last_v);
                    end
                end
                last_y = dout;
                last_v = dout_valid;
            end
        end
    end

    // R4: DC average through the cascade
    task automatic dc_check(input int x);
        int diff;
        for (int i = 0; i < 8; i++) step(x);
        obs_sum = 0;
        win = 1;
        for (int i = 0; i < 64; i++) step(x);
        win = 0;
        #1;
        diff = FS * obs_sum - 64 * x;
        checks++;
        if (diff > 4 * FS || diff < -4 * FS) begin
            failures++;
            $display("FAIL R4 dc x=%0d actual=%0d expected=%0d (+-%0d)",
                     x, FS * obs_sum, 64 * x, 4 * FS);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        model_clear();
        idle(2);
        rst_cycle(0, 0);              // R8 reset state
        rst_cycle(1, 777);            // R8 reset beats enable
        // R9: valid after exactly four enables, first word carries sample 0
        for (int i = 0; i < 6; i++) step(300);
        idle(3);                      // R7 idle holds
        for (int i = 0; i < 20; i++) step(0);
        dc_check(1000);               // R4
        dc_check(-1500);              // R4
        for (int i = 0; i < 40; i++) step(FS);       // R5 full scale
        for (int i = 0; i < 40; i++) step(-FS);      // R5
        for (int i = 0; i < 30; i++) step(-(1 << (W - 1)));  // R6
        for (int i = 0; i < 40; i++) begin           // R1 alternating
            step((i % 2 == 0) ? FS : -FS);
            if (i % 7 == 0) idle(1);                 // R7
        end
        for (int i = 0; i < 64; i++) step(-FS + i * 64);   // R2 ramp
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(int'($signed(lfsr[W-1:0])));
            if (i == 120) rst_cycle(1, 123);         // R8 mid-run with enable
        end
        rst_cycle(0, 0);
        idle(2);
        for (int i = 0; i < 8; i++) step(-2000);     // R9 restart
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule